// File: doc/BRIEF.md
# Indirect Byte-Wide Configuration Loader

This block lets a narrow host bus load a bank of 32-bit configuration registers. The host has a 3-bit address, an 8-bit data bus and a write strobe. Both are captured on the rising edge of the strobe. The host first fills four byte holding registers, one per byte lane. It then writes a target register number to the destination address, which starts a commit. The commit crosses into the core clock domain as a toggle. It is synchronized, edge-detected and turned into a single-cycle load pulse. The assembled word lands in the addressed register on the fourth core clock edge after the strobe edge.

Some registers are double-buffered. A commit to one of these fills only its staging copy. The staging copy moves to the visible register while the core-synchronous `sync_in` input is high, and only if that register's enable bit is set in the enable register. A separate address latches a read-source selector byte. That byte is only passed out on a port. The register bank itself is a generic stand-in.

Top module: `cfg_indirect_wr`

## Requirements
- R1: After reset, every configuration register, `rd_sel`, `load_busy` and `err_overlap` read zero.
- R2: Host addresses 0, 1, 2 and 3 load the byte lanes 7:0, 15:8, 23:16 and 31:24 of the pending word. The lanes may be written in any order.
- R3: A write to host address 4 commits the pending word to the register whose number equals the 8 data bits written. No other register changes.
- R4: The committed value first shows on `cfg_regs` after the fourth rising core clock edge that follows the strobe edge of the address-4 write. It is still the old value after the third.
- R5: A write to host address 5 sets `rd_sel` to the written byte and changes no configuration register.
- R6: Writes to host addresses 6 and 7 change neither the pending word nor `rd_sel`.
- R7: A commit whose register number is at or above `NUM_REGS` changes no register and does not set `err_overlap`.
- R8: A second address-4 write whose strobe edge comes 1 to 3 core clocks after an accepted one is dropped. It sets `err_overlap`, which stays set until reset. A commit issued after that window is accepted again.
- R9: A commit to a register flagged in `STAGED_MASK` leaves `cfg_regs` unchanged. The staged value appears on the next clock edge at which `sync_in` is high and bit i of register `EN_REG` is 1.
- R10: `sync_in` does not move a staged value whose enable bit in register `EN_REG` is 0.
- R11: Byte holding registers keep their contents across commits. A later commit reuses any lane that was not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| host_wr | input | 1 | Host write strobe; address and data are taken on its rising edge |
| host_addr | input | 3 | Host register select (0-3 byte lanes, 4 destination, 5 read select) |
| host_data | input | 8 | Host write data |
| sync_in | input | 1 | Core-synchronous event that moves enabled staged values |
| cfg_regs | output | NUM_REGS*32 | Visible configuration registers, register i at bits 32*i+31:32*i |
| rd_sel | output | 8 | Read-source selector byte |
| load_busy | output | 1 | Transfer window active after an accepted commit |
| err_overlap | output | 1 | Sticky flag: a commit arrived inside the transfer window |

## Verification
The bench builds the block with its defaults: eight registers, a two-flop synchronizer, registers 1 and 2 staged, and register 0 holding the enable bits. The two-stage synchronizer gives the four-edge latency that the bench measures edge by edge. Eight registers make numbers 8 and 255 out of range. The staged mask lets one sync pulse move an enabled register while a disabled one stays put. With the strobe placed mid-cycle, a back-to-back commit falls inside the three-clock window, which exercises the overlap drop and the sticky flag.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
   localparam int BYTE_W = 8;
   localparam int LANES  = 4;
   localparam int WORD_W = BYTE_W * LANES;

   localparam logic [2:0] HA_DEST = 3'd4;
   localparam logic [2:0] HA_RSEL = 3'd5;

   typedef struct packed {
      logic [BYTE_W-1:0] dest;
      logic [WORD_W-1:0] word;
   } xfer_t;
endpackage

// File: rtl/cfgw_host_capture.sv
module cfgw_host_capture
   import cfgw_pkg::*;
(
   input  logic              host_wr,
   input  logic              rst_n,
   input  logic [2:0]        host_addr,
   input  logic [BYTE_W-1:0] host_data,
   output logic              launch_tog,
   output xfer_t [1:0]       slots,
   output logic [BYTE_W-1:0] rd_sel
);
   logic [LANES-1:0][BYTE_W-1:0] lane_q;

   // Two launch slots, picked by the toggle, keep a commit in flight
   // from being overwritten by the next destination write.
   always_ff @(posedge host_wr or negedge rst_n) begin
      if (!rst_n) begin
         lane_q     <= '0;
         slots      <= '0;
         launch_tog <= 1'b0;
         rd_sel     <= '0;
      end else begin
         case (host_addr)
            3'd0, 3'd1, 3'd2, 3'd3: lane_q[host_addr[1:0]] <= host_data;
            HA_DEST: begin
               slots[~launch_tog] <= '{dest: host_data, word: lane_q};
               launch_tog         <= ~launch_tog;
            end
            HA_RSEL: rd_sel <= host_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfgw_load_sync.sv
module cfgw_load_sync
   import cfgw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch_tog,
   input  xfer_t [1:0] slots,
   output logic        commit_pulse,
   output xfer_t       commit,
   output logic        load_busy,
   output logic        err_overlap
);
   localparam int LAT    = SYNC_STAGES + 2;
   localparam int BUSY_W = $clog2(LAT);
   localparam logic [BUSY_W-1:0] BUSY_INIT = BUSY_W'(LAT - 1);

   logic [SYNC_STAGES-1:0] tog_s;
   logic                   tog_d;
   logic [BUSY_W-1:0]      busy_cnt;
   logic                   det;

   assign det       = tog_s[SYNC_STAGES-1] ^ tog_d;
   assign load_busy = (busy_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_s        <= '0;
         tog_d        <= 1'b0;
         busy_cnt     <= '0;
         commit_pulse <= 1'b0;
         commit       <= '0;
         err_overlap  <= 1'b0;
      end else begin
         tog_s        <= {tog_s[SYNC_STAGES-2:0], launch_tog};
         tog_d        <= tog_s[SYNC_STAGES-1];
         commit_pulse <= 1'b0;
         if (busy_cnt != '0) busy_cnt <= busy_cnt - BUSY_W'(1);
         if (det) begin
            if (busy_cnt != '0) begin
               err_overlap <= 1'b1;
            end else begin
               commit_pulse <= 1'b1;
               commit       <= slots[tog_s[SYNC_STAGES-1]];
               busy_cnt     <= BUSY_INIT;
            end
         end
      end
   end
endmodule

// File: rtl/cfgw_regfile.sv
module cfgw_regfile
   import cfgw_pkg::*;
#(
   parameter int          NUM_REGS    = 8,
   parameter logic [31:0] STAGED_MASK = 32'h0000_0006,
   parameter int          EN_REG      = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [BYTE_W-1:0]          wr_idx,
   input  logic [WORD_W-1:0]          wr_word,
   input  logic                       sync_in,
   output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [BYTE_W-1:0] IDX = BYTE_W'(gi);
      logic              hit;
      logic [WORD_W-1:0] act_q;
      assign hit = wr_en && (wr_idx == IDX);
      assign regs_flat[gi*WORD_W +: WORD_W] = act_q;

      if (STAGED_MASK[gi]) begin : g_staged
         logic [WORD_W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
               act_q   <= '0;
            end else begin
               if (hit) stage_q <= wr_word;
               if (sync_in && regs_flat[EN_REG*WORD_W + gi]) act_q <= stage_q;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   act_q <= '0;
            else if (hit) act_q <= wr_word;
         end
      end
   end
endmodule

// File: rtl/cfg_indirect_wr.sv
module cfg_indirect_wr
   import cfgw_pkg::*;
#(
   parameter int          NUM_REGS    = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] STAGED_MASK = 32'h0000_0006,
   parameter int          EN_REG      = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic [2:0]                 host_addr,
   input  logic [7:0]                 host_data,
   input  logic                       sync_in,
   output logic [NUM_REGS*32-1:0]     cfg_regs,
   output logic [7:0]                 rd_sel,
   output logic                       load_busy,
   output logic                       err_overlap
);
   if (NUM_REGS < 1 || NUM_REGS > 32) begin : g_bad_num
      $error("NUM_REGS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (EN_REG < 0 || EN_REG >= NUM_REGS) begin : g_bad_en
      $error("EN_REG must name an existing register");
   end else if (STAGED_MASK[EN_REG]) begin : g_bad_stage
      $error("the enable register cannot itself be staged");
   end

   logic        launch_tog;
   xfer_t [1:0] slots;
   logic        commit_pulse;
   xfer_t       commit;

   cfgw_host_capture u_host (
      .host_wr    (host_wr),
      .rst_n      (rst_n),
      .host_addr  (host_addr),
      .host_data  (host_data),
      .launch_tog (launch_tog),
      .slots      (slots),
      .rd_sel     (rd_sel)
   );

   cfgw_load_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_tog   (launch_tog),
      .slots        (slots),
      .commit_pulse (commit_pulse),
      .commit       (commit),
      .load_busy    (load_busy),
      .err_overlap  (err_overlap)
   );

   cfgw_regfile #(
      .NUM_REGS    (NUM_REGS),
      .STAGED_MASK (STAGED_MASK),
      .EN_REG      (EN_REG)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (commit_pulse),
      .wr_idx    (commit.dest),
      .wr_word   (commit.word),
      .sync_in   (sync_in),
      .regs_flat (cfg_regs)
   );
endmodule

// File: rtl/cfg_indirect_wr_chk.sv
module cfg_indirect_wr_chk #(
   parameter int NUM_REGS = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sync_in,
   input logic                   commit_pulse,
   input logic                   load_busy,
   input logic                   err_overlap,
   input logic [NUM_REGS*32-1:0] cfg_regs
);
   // R4: the load pulse lasts exactly one core cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |=> !commit_pulse);

   // R8: an accepted commit opens the transfer window
   a_r8_window_open: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> load_busy);

   // R8: the overlap flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_overlap |=> err_overlap);

   // R8: the overlap flag rises only out of an open window
   a_r8_err_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overlap) |-> $past(load_busy));

   // R3: registers move only after a load pulse or a sync event
   a_r3_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_regs) |-> ($past(commit_pulse) || $past(sync_in)));
endmodule

bind cfg_indirect_wr cfg_indirect_wr_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_in      (sync_in),
   .commit_pulse (commit_pulse),
   .load_busy    (load_busy),
   .err_overlap  (err_overlap),
   .cfg_regs     (cfg_regs)
);

// File: tb/tb_cfg_indirect_wr.sv
module tb_cfg_indirect_wr;
   localparam int CLK_P = 10;
   localparam int NREG  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic [2:0]        host_addr = '0;
   logic [7:0]        host_data = '0;
   logic              sync_in = 1'b0;
   logic [NREG*32-1:0] cfg_regs;
   logic [7:0]        rd_sel;
   logic              load_busy;
   logic              err_overlap;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cfg_indirect_wr #(
      .NUM_REGS    (NREG),
      .SYNC_STAGES (2),
      .STAGED_MASK (32'h0000_0006),
      .EN_REG      (0)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_addr   (host_addr),
      .host_data   (host_data),
      .sync_in     (sync_in),
      .cfg_regs    (cfg_regs),
      .rd_sel      (rd_sel),
      .load_busy   (load_busy),
      .err_overlap (err_overlap)
   );

   function automatic logic [31:0] reg_of(int i);
      return cfg_regs[i*32 +: 32];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // strobe rises one time unit after a falling clock edge
   task automatic host_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      host_data = d;
      #1 host_wr = 1'b1;
      #2 host_wr = 1'b0;
   endtask

   task automatic set_word(logic [31:0] w);
      host_write(3'd0, w[7:0]);
      host_write(3'd1, w[15:8]);
      host_write(3'd2, w[23:16]);
      host_write(3'd3, w[31:24]);
   endtask

   task automatic load_word(logic [7:0] dest, logic [31:0] w);
      set_word(w);
      host_write(3'd4, dest);
      repeat (6) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      for (int i = 0; i < NREG; i++) chk("R1 reg zero", reg_of(i), 32'h0);
      chk("R1 rd_sel", {24'h0, rd_sel}, 32'h0);
      chk("R1 busy", {31'h0, load_busy}, 32'h0);
      chk("R1 err", {31'h0, err_overlap}, 32'h0);
   endtask

   task automatic t_lanes;
      host_write(3'd3, 8'hA1);
      host_write(3'd0, 8'hD4);
      host_write(3'd2, 8'hB2);
      host_write(3'd1, 8'hC3);
      host_write(3'd4, 8'd3);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R2 lanes", reg_of(3), 32'hA1B2C3D4);
      chk("R3 other reg", reg_of(4), 32'h0);
      chk("R3 other reg", reg_of(0), 32'h0);
   endtask

   task automatic t_latency;
      set_word(32'h11223344);
      host_write(3'd4, 8'd5);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R4 old after third edge", reg_of(5), 32'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R4 new after fourth edge", reg_of(5), 32'h11223344);
      repeat (4) @(posedge clk);
   endtask

   task automatic t_retain;
      host_write(3'd0, 8'h99);
      host_write(3'd4, 8'd6);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R11 lanes retained", reg_of(6), 32'h11223399);
   endtask

   task automatic t_rsel;
      logic [NREG*32-1:0] snap = cfg_regs;
      host_write(3'd5, 8'h3C);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R5 rd_sel", {24'h0, rd_sel}, 32'h3C);
      chk("R5 no transfer", {31'h0, cfg_regs == snap}, 32'h1);
   endtask

   task automatic t_undef;
      host_write(3'd6, 8'hFF);
      host_write(3'd7, 8'hEE);
      chk("R6 rd_sel kept", {24'h0, rd_sel}, 32'h3C);
      host_write(3'd4, 8'd7);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R6 word kept", reg_of(7), 32'h11223399);
   endtask

   task automatic t_range;
      logic [NREG*32-1:0] snap = cfg_regs;
      host_write(3'd0, 8'h55);
      host_write(3'd4, 8'd8);
      repeat (6) @(posedge clk);
      host_write(3'd4, 8'hFF);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R7 regs unchanged", {31'h0, cfg_regs == snap}, 32'h1);
      chk("R7 no error", {31'h0, err_overlap}, 32'h0);
   endtask

   task automatic t_overlap;
      set_word(32'hCAFE0001);
      host_write(3'd4, 8'd4);
      host_write(3'd4, 8'd7);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk("R8 first accepted", reg_of(4), 32'hCAFE0001);
      chk("R8 second dropped", reg_of(7), 32'h11223399);
      chk("R8 error set", {31'h0, err_overlap}, 32'h1);
      load_word(8'd7, 32'h0BADF00D);
      chk("R8 later accepted", reg_of(7), 32'h0BADF00D);
      chk("R8 error sticky", {31'h0, err_overlap}, 32'h1);
   endtask

   task automatic t_sync;
      load_word(8'd1, 32'h12345678);
      load_word(8'd2, 32'h87654321);
      chk("R9 staged hidden", reg_of(1), 32'h0);
      chk("R9 staged hidden", reg_of(2), 32'h0);
      load_word(8'd0, 32'h00000002);
      chk("R9 no move without sync", reg_of(1), 32'h0);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      chk("R9 moved on sync", reg_of(1), 32'h12345678);
      chk("R10 disabled stays", reg_of(2), 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lanes();
      t_latency();
      t_retain();
      t_rsel();
      t_undef();
      t_range();
      t_overlap();
      t_sync();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule